// File: doc/BRIEF.md
# Multi-Chain Scan Test Sequencer

This block runs a full-scan test on a bank of flip-flops wrapped around a small combinational core. The bank is cut into several chains of equal length that shift side by side. Every cell has a two-way mux in front of its D input. When scan-enable is high, the cell takes the output of the cell before it. When scan-enable is low, it takes the core's next-state value. After a start pulse the sequencer first proves that the chains can shift, using a repeating flush sequence. It then takes each pattern in turn: the stimulus goes in, one capture clock follows, and the captured response comes out while the next stimulus goes in.

The tester supplies, as parallel words, the stimulus for the pattern shown on `ld_pat` and the expected response for the pattern shown on `ul_pat`. It also holds the primary inputs for the pattern being loaded. The sequencer compares every bit shifted out with the expected bit. On the first mismatch it records where the mismatch occurred, and it raises `done` once the last response has left the chains.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `fail_flush` are 0, `scan_en` is 1, and `ld_pat` reads 0.
- R2: A start pulse begins a flush phase of CLEN+4 shift cycles. In flush cycle t every chain receives bit 1 of t, which gives the sequence 0,0,1,1 repeating. From cycle CLEN on, each chain output is compared with the bit injected CLEN cycles earlier, and a mismatch sets `fail` and `fail_flush`.
- R3: Cell k of chain c is bank bit c*CLEN+k. Scan-in feeds cell 0, and cell CLEN-1 is the scan output. `stim_vec` and `exp_vec` use the same bit position for the same cell.
- R4: Each pattern spends CLEN cycles with `scan_en` high, followed by exactly one cycle with `scan_en` low. A whole run therefore has exactly NPAT capture cycles, each lasting one cycle.
- R5: On a capture edge, bank bit i becomes (q[i] AND q[(i+1) mod NFF]) XOR q[(i+3) mod NFF] XOR pi_in[i mod PIW].
- R6: The response of pattern p shifts out during the load of pattern p+1. Only the final response needs CLEN extra cycles. `done` rises CLEN+4 + NPAT*(CLEN+1) + CLEN cycles after the edge that accepts start.
- R7: Each shifted-out bit of pattern `ul_pat` is compared with `exp_vec`. `fail` is sticky. `fail_pat` and `fail_chain` hold the first failing pattern and, within that cycle, the lowest failing chain. Later mismatches do not change them.
- R8: A start pulse while `busy` is 1 has no effect on the sequence or on the recorded results.
- R9: `ld_pat` stays the same from the first load cycle of a pattern through its capture cycle. It advances only on the edge that ends the capture, so the primary inputs tied to it stay stable over that span.
- R10: `done` holds until the next start. A start issued while `done` is 1 clears `done`, `fail` and `fail_flush` and runs the test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (ignored while busy) |
| pi_in | input | PIW | Primary inputs to the core |
| stim_vec | input | NFF | Stimulus for pattern `ld_pat`, bit c*CLEN+k for chain c cell k |
| exp_vec | input | NFF | Expected response for pattern `ul_pat`, same layout |
| ld_pat | output | PW | Pattern being shifted in |
| ul_pat | output | PW | Pattern whose response is being shifted out |
| scan_en | output | 1 | Shift (1) or capture (0) select for the bank |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last response fully unloaded |
| fail | output | 1 | Sticky mismatch flag |
| fail_flush | output | 1 | First mismatch occurred during the flush |
| fail_pat | output | PW | Pattern index of the first mismatch |
| fail_chain | output | CW | Chain index of the first mismatch |

## Verification
Two things share a clock cycle during every load. Stimulus of one pattern is entering the chains while the captured response of the previous pattern is being compared. Also, several chains can mismatch on the same edge. The bench uses random stimulus and primary inputs, with expected words computed from the core equation. It then corrupts expected bits: in two chains in the same shift cycle, in a later pattern, in the first bit out and in the last bit of the tail unload. Each case is judged by the recorded pattern and chain and by the cycle on which `done` rises.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FLUSH = 3'd1,
    ST_LOAD  = 3'd2,
    ST_CAPT  = 3'd3,
    ST_UNLD  = 3'd4,
    ST_DONE  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/scan_core.sv
// Combinational next-state logic of the register bank under test.
module scan_core #(
  parameter int NFF = 32,
  parameter int PIW = 4
) (
  input  logic [NFF-1:0] q,
  input  logic [PIW-1:0] pi_in,
  output logic [NFF-1:0] nxt
);
  for (genvar i = 0; i < NFF; i++) begin : g_bit
    assign nxt[i] = (q[i] & q[(i+1) % NFF]) ^ q[(i+3) % NFF] ^ pi_in[i % PIW];
  end
endmodule

// File: rtl/scan_bank.sv
// Register bank with mux-D scan cells split into NCH chains of CLEN cells.
module scan_bank #(
  parameter int NCH  = 4,
  parameter int CLEN = 8,
  parameter int PIW  = 4,
  localparam int NFF = NCH * CLEN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scan_en,
  input  logic [NCH-1:0] si,
  input  logic [PIW-1:0] pi_in,
  output logic [NCH-1:0] so
);
  logic [NFF-1:0] q;
  logic [NFF-1:0] nxt;
  logic [NFF-1:0] shin;

  scan_core #(.NFF(NFF), .PIW(PIW)) u_core (.q(q), .pi_in(pi_in), .nxt(nxt));

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    for (genvar k = 0; k < CLEN; k++) begin : g_cell
      if (k == 0) begin : g_head
        assign shin[c*CLEN] = si[c];
      end else begin : g_body
        assign shin[c*CLEN+k] = q[c*CLEN+k-1];
      end
    end
    assign so[c] = q[c*CLEN+CLEN-1];
  end

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (scan_en) q <= shin;
    else              q <= nxt;
  end

  // R9: primary inputs stable across the capture edge relative to the last shift
  p_pi_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !scan_en |-> $stable(pi_in));
endmodule

// File: rtl/scan_ctrl.sv
// Phase sequencer: flush, overlapped load/unload, single-cycle capture, tail unload.
module scan_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CLEN = 8,
  parameter int NPAT = 6,
  localparam int NFF  = NCH * CLEN,
  localparam int PW   = $clog2(NPAT),
  localparam int CNTW = $clog2(CLEN + 4),
  localparam int KW   = $clog2(CLEN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NFF-1:0] stim_vec,
  input  logic [NFF-1:0] exp_vec,
  output logic [NCH-1:0] si,
  output logic [NCH-1:0] ref_bit,
  output logic           chk_en,
  output logic           clr,
  output logic           in_flush,
  output logic [PW-1:0]  pat,
  output logic [PW-1:0]  ul_pat,
  output logic           scan_en,
  output logic           busy,
  output logic           done
);
  localparam logic [CNTW-1:0] FL_LAST = CNTW'(CLEN + 3);
  localparam logic [CNTW-1:0] SH_LAST = CNTW'(CLEN - 1);
  localparam logic [CNTW-1:0] CL      = CNTW'(CLEN);
  localparam logic [PW-1:0]   P_LAST  = PW'(NPAT - 1);

  seq_state_t      st;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] lag;
  logic [KW-1:0]   rev;

  assign clr     = start && (st == ST_IDLE || st == ST_DONE);
  assign scan_en = (st != ST_CAPT);
  assign busy    = (st == ST_FLUSH) || (st == ST_LOAD) || (st == ST_CAPT) || (st == ST_UNLD);
  assign done    = (st == ST_DONE);
  assign in_flush = (st == ST_FLUSH);
  assign ul_pat  = (st == ST_LOAD && pat != '0) ? pat - PW'(1) : pat;
  assign lag     = cnt - CL;
  assign rev     = KW'(CLEN - 1) - cnt[KW-1:0];
  assign chk_en  = (st == ST_FLUSH && cnt >= CL) ||
                   (st == ST_LOAD && pat != '0) || (st == ST_UNLD);

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    logic [CLEN-1:0] s_seg, e_seg;
    assign s_seg = stim_vec[c*CLEN +: CLEN];
    assign e_seg = exp_vec[c*CLEN +: CLEN];
    always_comb begin
      si[c]      = 1'b0;
      ref_bit[c] = 1'b0;
      if (st == ST_FLUSH) begin
        si[c]      = cnt[1];
        ref_bit[c] = lag[1];
      end else if (st == ST_LOAD) begin
        si[c]      = s_seg[rev];
        ref_bit[c] = e_seg[rev];
      end else if (st == ST_UNLD) begin
        ref_bit[c] = e_seg[rev];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
      pat <= '0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: if (start) begin
          st  <= ST_FLUSH;
          cnt <= '0;
          pat <= '0;
        end
        ST_FLUSH: if (cnt == FL_LAST) begin
          st  <= ST_LOAD;
          cnt <= '0;
        end else cnt <= cnt + CNTW'(1);
        ST_LOAD: if (cnt == SH_LAST) st <= ST_CAPT;
                 else cnt <= cnt + CNTW'(1);
        ST_CAPT: begin
          cnt <= '0;
          if (pat == P_LAST) st <= ST_UNLD;
          else begin
            st  <= ST_LOAD;
            pat <= pat + PW'(1);
          end
        end
        ST_UNLD: if (cnt == SH_LAST) st <= ST_DONE;
                 else cnt <= cnt + CNTW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: capture lasts one cycle and shifting resumes right after
  p_capt_single_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT) |=> (st == ST_LOAD || st == ST_UNLD));
  // R4: a full chain length of shifting precedes every capture
  p_load_len_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD && cnt == SH_LAST) |=> (st == ST_CAPT));
  // R2: an accepted start always begins with the flush
  p_flush_first_r2: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE || st == ST_DONE) && start) |=> (st == ST_FLUSH && cnt == '0));
  // R8: start during a load does not disturb the sequence
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD && start) |=> (st == ST_LOAD || st == ST_CAPT));
  // R9: the load index does not move into the capture cycle
  p_ld_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT) |-> $stable(pat));
endmodule

// File: rtl/scan_cmp.sv
// Response comparator with sticky first-failure record.
module scan_cmp #(
  parameter int NCH  = 4,
  parameter int NPAT = 6,
  localparam int PW  = $clog2(NPAT),
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           chk_en,
  input  logic           in_flush,
  input  logic [NCH-1:0] so,
  input  logic [NCH-1:0] ref_bit,
  input  logic [PW-1:0]  tag,
  output logic           fail,
  output logic           fail_flush,
  output logic [PW-1:0]  fail_pat,
  output logic [CW-1:0]  fail_chain
);
  logic [NCH-1:0] mm;
  logic [CW-1:0]  low;

  assign mm = chk_en ? (so ^ ref_bit) : '0;

  always_comb begin
    low = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mm[i]) low = CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail       <= 1'b0;
      fail_flush <= 1'b0;
      fail_pat   <= '0;
      fail_chain <= '0;
    end else if (!fail && mm != '0) begin
      fail       <= 1'b1;
      fail_flush <= in_flush;
      fail_pat   <= tag;
      fail_chain <= low;
    end
  end

  // R7: the first failure record is frozen until a new run clears it
  p_first_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> (fail && $stable(fail_pat) && $stable(fail_chain) && $stable(fail_flush)));
  // R7: any enabled mismatch leaves the fail flag set
  p_mm_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (mm != '0 && !clr) |=> fail);
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
  parameter int NCH  = 4,
  parameter int CLEN = 8,
  parameter int NPAT = 6,
  parameter int PIW  = 4,
  localparam int NFF = NCH * CLEN,
  localparam int PW  = $clog2(NPAT),
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [PIW-1:0] pi_in,
  input  logic [NFF-1:0] stim_vec,
  input  logic [NFF-1:0] exp_vec,
  output logic [PW-1:0]  ld_pat,
  output logic [PW-1:0]  ul_pat,
  output logic           scan_en,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic           fail_flush,
  output logic [PW-1:0]  fail_pat,
  output logic [CW-1:0]  fail_chain
);
  logic [NCH-1:0] si, so, ref_bit;
  logic           chk_en, clr, in_flush;

  scan_ctrl #(.NCH(NCH), .CLEN(CLEN), .NPAT(NPAT)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stim_vec(stim_vec), .exp_vec(exp_vec),
    .si(si), .ref_bit(ref_bit), .chk_en(chk_en), .clr(clr), .in_flush(in_flush),
    .pat(ld_pat), .ul_pat(ul_pat), .scan_en(scan_en), .busy(busy), .done(done)
  );

  scan_bank #(.NCH(NCH), .CLEN(CLEN), .PIW(PIW)) u_bank (
    .clk(clk), .rst(rst), .scan_en(scan_en), .si(si), .pi_in(pi_in), .so(so)
  );

  scan_cmp #(.NCH(NCH), .NPAT(NPAT)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .chk_en(chk_en), .in_flush(in_flush),
    .so(so), .ref_bit(ref_bit), .tag(ul_pat), .fail(fail), .fail_flush(fail_flush),
    .fail_pat(fail_pat), .fail_chain(fail_chain)
  );

  // R6: completion is never reported while a run is still in progress
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && scan_en));
endmodule

// File: tb/scan_test_seq_bench.sv
module scan_test_seq_bench;
  localparam int NCH = 4, CLEN = 8, NPAT = 6, PIW = 4;
  localparam int NFF = NCH * CLEN;
  localparam int PW = $clog2(NPAT), CW = $clog2(NCH);
  localparam int TOT = CLEN + 4 + NPAT * (CLEN + 1) + CLEN;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [PIW-1:0] pi_in;
  logic [NFF-1:0] stim_vec, exp_vec;
  logic [PW-1:0]  ld_pat, ul_pat, fail_pat;
  logic [CW-1:0]  fail_chain;
  logic scan_en, busy, done, fail, fail_flush;

  logic [NFF-1:0] stim_mem [NPAT];
  logic [NFF-1:0] exp_mem  [NPAT];
  logic [PIW-1:0] pi_mem   [NPAT];

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign stim_vec = stim_mem[ld_pat];
  assign exp_vec  = exp_mem[ul_pat];
  assign pi_in    = pi_mem[ld_pat];

  scan_test_seq #(.NCH(NCH), .CLEN(CLEN), .NPAT(NPAT), .PIW(PIW)) u_scan_test_seq (
    .clk(clk), .rst(rst), .start(start), .pi_in(pi_in), .stim_vec(stim_vec),
    .exp_vec(exp_vec), .ld_pat(ld_pat), .ul_pat(ul_pat), .scan_en(scan_en),
    .busy(busy), .done(done), .fail(fail), .fail_flush(fail_flush),
    .fail_pat(fail_pat), .fail_chain(fail_chain)
  );

  function automatic logic [NFF-1:0] model_capture(input logic [NFF-1:0] q, input logic [PIW-1:0] p);
    logic [NFF-1:0] r;
    for (int i = 0; i < NFF; i++)
      r[i] = (q[i] & q[(i+1) % NFF]) ^ q[(i+3) % NFF] ^ p[i % PIW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic prep();
    for (int p = 0; p < NPAT; p++) begin
      stim_mem[p] = $urandom();
      pi_mem[p]   = PIW'($urandom());
      exp_mem[p]  = model_capture(stim_mem[p], pi_mem[p]);
    end
  endtask

  // Runs one test; returns the negedge index at which done was first seen.
  task automatic run(input int mid_start, output int seen, output int lows,
                     output int maxrun, output int ld_bad);
    int k, r;
    logic [PW-1:0] prev_ld;
    lows = 0; maxrun = 0; ld_bad = 0; r = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    prev_ld = ld_pat;
    while (!done && k <= 4 * TOT) begin
      if (!scan_en) begin
        lows++; r++;
        if (r > maxrun) maxrun = r;
        if (ld_pat != prev_ld) ld_bad++;
      end else r = 0;
      prev_ld = ld_pat;
      start = (k == mid_start);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    seen = k;
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seen, lows, maxrun, ld_bad;
    void'($urandom(32'd2024));
    prep();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && !fail_flush, "R1 flags", {busy, done, fail, fail_flush}, 0);
    chk(scan_en == 1'b1, "R1 scan_en", scan_en, 1);
    chk(ld_pat == '0, "R1 ld_pat", ld_pat, 0);

    // Clean run with a start pulse landing mid-run (R8)
    run(30, seen, lows, maxrun, ld_bad);
    chk(seen == TOT + 1, "R6 R8 done cycle", seen, TOT + 1);
    chk(lows == NPAT, "R4 capture count", lows, NPAT);
    chk(maxrun == 1, "R4 capture length", maxrun, 1);
    chk(ld_bad == 0, "R9 ld_pat hold", ld_bad, 0);
    chk(!fail, "R2 R3 R5 R7 clean run", fail, 0);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R10 done holds", done, 1);

    // Two chains mismatch in one cycle of pattern 2, plus a later one in pattern 4 (R7)
    prep();
    exp_mem[2][1*CLEN + 5] = ~exp_mem[2][1*CLEN + 5];
    exp_mem[2][3*CLEN + 5] = ~exp_mem[2][3*CLEN + 5];
    exp_mem[4][0*CLEN + 2] = ~exp_mem[4][0*CLEN + 2];
    run(50, seen, lows, maxrun, ld_bad);
    chk(seen == TOT + 1, "R6 done with errors", seen, TOT + 1);
    chk(fail && !fail_flush, "R7 fail set", {fail, fail_flush}, 2);
    chk(fail_pat == PW'(2), "R7 first pattern", fail_pat, 2);
    chk(fail_chain == CW'(1), "R7 lowest chain", fail_chain, 1);

    // Clean rerun clears the record (R10)
    prep();
    run(0, seen, lows, maxrun, ld_bad);
    chk(!fail && done, "R10 cleared by start", fail, 0);

    // Last bit out of the tail unload: last pattern, chain NCH-1, cell 0 (R6, R3)
    prep();
    exp_mem[NPAT-1][(NCH-1)*CLEN] = ~exp_mem[NPAT-1][(NCH-1)*CLEN];
    run(0, seen, lows, maxrun, ld_bad);
    chk(fail && fail_pat == PW'(NPAT-1), "R6 tail pattern", fail_pat, NPAT - 1);
    chk(fail_chain == CW'(NCH-1), "R3 tail chain", fail_chain, NCH - 1);

    // First bit out: pattern 0, chain 0, cell CLEN-1 (R3, R7)
    prep();
    exp_mem[0][CLEN-1] = ~exp_mem[0][CLEN-1];
    run(0, seen, lows, maxrun, ld_bad);
    chk(fail && fail_pat == '0 && fail_chain == '0, "R3 first out", {fail_pat, fail_chain}, 0);
    chk(!fail_flush, "R2 flush clean", fail_flush, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule